// File: doc/BRIEF.md
# Split Row/Column Command Scheduler

This block schedules commands for a narrow, packet-based DRAM channel. Row commands (activate and precharge) and column commands (read and write) go out on two separate command buses. While one transaction waits for its data slot or issues its column access, the next transaction can open its row. The block keeps an open-row table for every device on the channel. Each device has a row of banks, and each bank shares sense amplifiers with the banks on either side of it. For this reason, opening a bank first requires both of its neighbours to be closed.

Requests enter one at a time through a valid/ready pair. Each request names a device, a bank, a row and a column, and says whether it reads or writes. An accepted request goes through a row stage, which issues any precharges and the activate. It then goes through a column stage, which waits for the activate-to-column delay and for a free slot on the shared data path. Every column command books one data slot, during which a single device drives the 16-bit data path. The block reports that slot, the device that owns it and its direction.

Top module: `splitCmdSched`

## Requirements
- R1: After reset, `reqReady` is 1, no row or column command is issued and `dataBusy` is 0.
- R2: A request whose bank and both neighbours are closed gets an activate (`rowCmdAct`=1) one cycle after it is accepted. Its column command follows T_RCD (default 3) cycles after the activate, which is 4 cycles after acceptance. Banks 0 and the last bank each have only one neighbour.
- R3: A request that finds its own row already open issues no row command. Its column command follows 2 cycles after acceptance.
- R4: If the target bank holds a different row, a precharge (`rowCmdAct`=0) is issued for that bank. The activate follows no sooner than T_RP (default 3) cycles after the last precharge. With defaults, the column command comes 7 cycles after acceptance.
- R5: Open neighbour banks are precharged before the target is activated, lowest bank number first, one precharge per cycle. With two open neighbours, the column command comes 8 cycles after acceptance. A bank two positions away is not affected.
- R6: Bank state is kept per device: an open bank on one device causes no precharge for a request to another device.
- R7: A row command for one transaction and a column command for another transaction can be issued in the same cycle.
- R8: A column command issued in cycle t makes `dataBusy` 1 in cycles t+1 to t+BURST (BURST default 8, one 32-byte transfer). In those cycles `dataDev` and `dataWrite` give the command's device and direction (`colCmdWrite`=1 means write). Two column commands are never closer than BURST cycles apart.
- R9: When the next command is otherwise ready, a read after a read, including a read to a different device, and a write after a read both follow exactly BURST cycles after the previous column command. The data bursts therefore run back to back.
- R10: A read after a write follows BURST+WR_GAP cycles (default 10) after the write's column command.
- R11: A bank that a column-stage transaction is using is not precharged until that transaction's column command has issued; the precharge then comes in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | A request is presented |
| reqReady | output | 1 | The row stage is free, so the request is accepted this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqDev | input | DEV_W | Target device |
| reqBank | input | BANK_W | Target bank |
| reqRow | input | ROW_W | Target row |
| reqCol | input | COL_W | Target column |
| rowCmdValid | output | 1 | A row command is issued this cycle |
| rowCmdAct | output | 1 | 1 = activate, 0 = precharge |
| rowCmdDev | output | DEV_W | Device of the row command |
| rowCmdBank | output | BANK_W | Bank of the row command |
| rowCmdRow | output | ROW_W | Row that is activated |
| colCmdValid | output | 1 | A column command is issued this cycle |
| colCmdWrite | output | 1 | 1 = write, 0 = read |
| colCmdDev | output | DEV_W | Device of the column command |
| colCmdBank | output | BANK_W | Bank of the column command |
| colCmdCol | output | COL_W | Column of the column command |
| dataBusy | output | 1 | A data slot occupies the data path |
| dataWrite | output | 1 | Direction of the current data slot |
| dataDev | output | DEV_W | Device that owns the current data slot |

## Verification
The interesting collision is the activate for a second transaction landing in the same cycle as the first transaction's column command, on the other bus. The bench provokes it by presenting a second request, to another device, right behind a first request to a closed bank. It then checks that both buses were active in one cycle. It also checks that the second read's column command follows exactly BURST cycles later, so the data path never idles. A related clash is a pending precharge on the very bank the column stage still owns. The bench judges that case by requiring the precharge to appear one cycle after that column command.

// File: rtl/splitCmdSchedPkg.sv
package splitCmdSchedPkg;

  // strobes from the control to the datapath, one cycle wide
  typedef struct packed {
    logic accept;    // load request into the row stage
    logic handoff;   // move row-stage transaction into the column stage
    logic issuePre;  // precharge the selected conflicting bank
    logic issueAct;  // activate the row-stage target
    logic issueCol;  // column command leaves; book the data slot
  } schedStrobeT;

endpackage

// File: rtl/splitCmdSchedDp.sv
module splitCmdSchedDp
  import splitCmdSchedPkg::*;
#(
  parameter int NUM_DEV  = 32,
  parameter int NUM_BANK = 16,
  parameter int ROW_W    = 8,
  parameter int COL_W    = 6,
  parameter int DEV_W    = $clog2(NUM_DEV),
  parameter int BANK_W   = $clog2(NUM_BANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  schedStrobeT       stb,
  input  logic              reqWrite,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  output logic              rowHit,
  output logic              conflictAny,
  output logic              preHitsCol,
  output logic [BANK_W-1:0] preBank,
  output logic [DEV_W-1:0]  rowDev,
  output logic [BANK_W-1:0] rowBank,
  output logic [ROW_W-1:0]  rowRow,
  output logic              colWrite,
  output logic [DEV_W-1:0]  colDev,
  output logic [BANK_W-1:0] colBank,
  output logic [COL_W-1:0]  colCol,
  output logic              dataWrite,
  output logic [DEV_W-1:0]  dataDev
);

  logic              rowWriteQ;
  logic [COL_W-1:0]  rowColQ;
  logic [NUM_BANK-1:0] openMask [NUM_DEV];
  logic [ROW_W-1:0]  openRow [NUM_DEV][NUM_BANK];
  logic [NUM_BANK-1:0] devMask;
  logic [NUM_BANK-1:0] conflict;

  assign devMask = openMask[rowDev];

  // a bank conflicts when it is open and is either a neighbour of the
  // target or the target itself holding another row
  for (genvar g = 0; g < NUM_BANK; g++) begin : gBank
    logic nearLo, nearHi, self;
    assign self = (rowBank == BANK_W'(g));
    if (g > 0) begin : gLo
      assign nearLo = (rowBank == BANK_W'(g - 1));
    end else begin : gLoEdge
      assign nearLo = 1'b0;
    end
    if (g < NUM_BANK - 1) begin : gHi
      assign nearHi = (rowBank == BANK_W'(g + 1));
    end else begin : gHiEdge
      assign nearHi = 1'b0;
    end
    assign conflict[g] = devMask[g] &&
                         (nearLo || nearHi || (self && openRow[rowDev][g] != rowRow));
  end

  assign conflictAny = |conflict;
  assign rowHit      = devMask[rowBank] && (openRow[rowDev][rowBank] == rowRow);
  assign preHitsCol  = (rowDev == colDev) && (preBank == colBank);

  always_comb begin
    preBank = '0;
    for (int i = NUM_BANK - 1; i >= 0; i--) begin
      if (conflict[i]) preBank = BANK_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rowWriteQ <= 1'b0;
      rowDev    <= '0;
      rowBank   <= '0;
      rowRow    <= '0;
      rowColQ   <= '0;
      colWrite  <= 1'b0;
      colDev    <= '0;
      colBank   <= '0;
      colCol    <= '0;
      dataWrite <= 1'b0;
      dataDev   <= '0;
      for (int d = 0; d < NUM_DEV; d++) begin
        openMask[d] <= '0;
        for (int b = 0; b < NUM_BANK; b++) openRow[d][b] <= '0;
      end
    end else begin
      if (stb.accept) begin
        rowWriteQ <= reqWrite;
        rowDev    <= reqDev;
        rowBank   <= reqBank;
        rowRow    <= reqRow;
        rowColQ   <= reqCol;
      end
      if (stb.handoff) begin
        colWrite <= rowWriteQ;
        colDev   <= rowDev;
        colBank  <= rowBank;
        colCol   <= rowColQ;
      end
      if (stb.issuePre) openMask[rowDev][preBank] <= 1'b0;
      if (stb.issueAct) begin
        openMask[rowDev][rowBank] <= 1'b1;
        openRow[rowDev][rowBank]  <= rowRow;
      end
      if (stb.issueCol) begin
        dataWrite <= colWrite;
        dataDev   <= colDev;
      end
    end
  end

endmodule

// File: rtl/splitCmdSchedCtrl.sv
module splitCmdSchedCtrl
  import splitCmdSchedPkg::*;
#(
  parameter int BURST  = 8,
  parameter int WR_GAP = 2,
  parameter int T_RP   = 3,
  parameter int T_RCD  = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        rowHit,
  input  logic        conflictAny,
  input  logic        preHitsCol,
  input  logic        colWrite,
  output schedStrobeT stb,
  output logic        reqReady,
  output logic        rowCmdValid,
  output logic        rowCmdAct,
  output logic        colCmdValid,
  output logic        dataBusy
);

  localparam int CNT_W = $clog2(BURST + WR_GAP + T_RP + T_RCD + 1);
  localparam logic [CNT_W-1:0] RP_LOAD    = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] RCD_LOAD   = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] SLOT_LOAD  = CNT_W'(BURST - 1);
  localparam logic [CNT_W-1:0] WRRD_LOAD  = CNT_W'(BURST - 1 + WR_GAP);
  localparam logic [CNT_W-1:0] DATA_LOAD  = CNT_W'(BURST);

  logic rowFull, colFull;
  logic [CNT_W-1:0] rpCnt, rcdCnt, colRcdCnt, gapCnt, rdGapCnt, dataCnt;

  function automatic logic [CNT_W-1:0] dec(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - CNT_W'(1);
  endfunction

  always_comb begin
    stb.issueCol = colFull && (colRcdCnt == '0) && (gapCnt == '0) &&
                   (colWrite || (rdGapCnt == '0));
    stb.issuePre = rowFull && !rowHit && conflictAny && !(colFull && preHitsCol);
    stb.issueAct = rowFull && !rowHit && !conflictAny && (rpCnt == '0);
    stb.handoff  = rowFull && rowHit && (!colFull || stb.issueCol);
    stb.accept   = reqValid && !rowFull;
  end

  assign reqReady    = !rowFull;
  assign rowCmdValid = stb.issuePre || stb.issueAct;
  assign rowCmdAct   = stb.issueAct;
  assign colCmdValid = stb.issueCol;
  assign dataBusy    = (dataCnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rowFull   <= 1'b0;
      colFull   <= 1'b0;
      rpCnt     <= '0;
      rcdCnt    <= '0;
      colRcdCnt <= '0;
      gapCnt    <= '0;
      rdGapCnt  <= '0;
      dataCnt   <= '0;
    end else begin
      if (stb.accept)       rowFull <= 1'b1;
      else if (stb.handoff) rowFull <= 1'b0;
      if (stb.handoff)       colFull <= 1'b1;
      else if (stb.issueCol) colFull <= 1'b0;
      rpCnt     <= stb.issuePre ? RP_LOAD : dec(rpCnt);
      rcdCnt    <= stb.issueAct ? RCD_LOAD : dec(rcdCnt);
      colRcdCnt <= stb.handoff ? dec(rcdCnt) : dec(colRcdCnt);
      gapCnt    <= stb.issueCol ? SLOT_LOAD : dec(gapCnt);
      rdGapCnt  <= (stb.issueCol && colWrite) ? WRRD_LOAD : dec(rdGapCnt);
      dataCnt   <= stb.issueCol ? DATA_LOAD : dec(dataCnt);
    end
  end

endmodule

// File: rtl/splitCmdSched.sv
module splitCmdSched
  import splitCmdSchedPkg::*;
#(
  parameter int NUM_DEV  = 32,
  parameter int NUM_BANK = 16,
  parameter int ROW_W    = 8,
  parameter int COL_W    = 6,
  parameter int BURST    = 8,
  parameter int WR_GAP   = 2,
  parameter int T_RP     = 3,
  parameter int T_RCD    = 3,
  localparam int DEV_W   = $clog2(NUM_DEV),
  localparam int BANK_W  = $clog2(NUM_BANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  output logic              rowCmdValid,
  output logic              rowCmdAct,
  output logic [DEV_W-1:0]  rowCmdDev,
  output logic [BANK_W-1:0] rowCmdBank,
  output logic [ROW_W-1:0]  rowCmdRow,
  output logic              colCmdValid,
  output logic              colCmdWrite,
  output logic [DEV_W-1:0]  colCmdDev,
  output logic [BANK_W-1:0] colCmdBank,
  output logic [COL_W-1:0]  colCmdCol,
  output logic              dataBusy,
  output logic              dataWrite,
  output logic [DEV_W-1:0]  dataDev
);

  schedStrobeT       stb;
  logic              rowHit, conflictAny, preHitsCol;
  logic [BANK_W-1:0] preBank, rowBank;

  splitCmdSchedCtrl #(
    .BURST(BURST), .WR_GAP(WR_GAP), .T_RP(T_RP), .T_RCD(T_RCD)
  ) i_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid),
    .rowHit(rowHit), .conflictAny(conflictAny), .preHitsCol(preHitsCol),
    .colWrite(colCmdWrite), .stb(stb), .reqReady(reqReady),
    .rowCmdValid(rowCmdValid), .rowCmdAct(rowCmdAct),
    .colCmdValid(colCmdValid), .dataBusy(dataBusy)
  );

  splitCmdSchedDp #(
    .NUM_DEV(NUM_DEV), .NUM_BANK(NUM_BANK), .ROW_W(ROW_W), .COL_W(COL_W),
    .DEV_W(DEV_W), .BANK_W(BANK_W)
  ) i_dp (
    .clk(clk), .rst(rst), .stb(stb),
    .reqWrite(reqWrite), .reqDev(reqDev), .reqBank(reqBank),
    .reqRow(reqRow), .reqCol(reqCol),
    .rowHit(rowHit), .conflictAny(conflictAny), .preHitsCol(preHitsCol),
    .preBank(preBank), .rowDev(rowCmdDev), .rowBank(rowBank), .rowRow(rowCmdRow),
    .colWrite(colCmdWrite), .colDev(colCmdDev), .colBank(colCmdBank),
    .colCol(colCmdCol), .dataWrite(dataWrite), .dataDev(dataDev)
  );

  // precharge names the conflicting bank, activate names the target
  assign rowCmdBank = rowCmdAct ? rowBank : preBank;

endmodule

// File: rtl/splitCmdSchedChecker.sv
module splitCmdSchedChecker #(
  parameter int BURST  = 8,
  parameter int WR_GAP = 2,
  parameter int T_RP   = 3
) (
  input logic clk,
  input logic rst,
  input logic rowCmdValid,
  input logic rowCmdAct,
  input logic colCmdValid,
  input logic colCmdWrite,
  input logic dataBusy
);

  localparam int SAT = BURST + WR_GAP + T_RP + 1;

  int sinceCol, sinceWr, sincePre;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceCol <= SAT;
      sinceWr  <= SAT;
      sincePre <= SAT;
    end else begin
      sinceCol <= colCmdValid ? 1 : ((sinceCol < SAT) ? sinceCol + 1 : sinceCol);
      sinceWr  <= (colCmdValid && colCmdWrite) ? 1 : ((sinceWr < SAT) ? sinceWr + 1 : sinceWr);
      sincePre <= (rowCmdValid && !rowCmdAct) ? 1 : ((sincePre < SAT) ? sincePre + 1 : sincePre);
    end
  end

  AST_COL_SPACING: assert property (@(posedge clk) disable iff (rst)
    colCmdValid |-> sinceCol >= BURST); // R8
  AST_DATA_AFTER_COL: assert property (@(posedge clk) disable iff (rst)
    colCmdValid |=> dataBusy); // R8
  AST_RD_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
    (colCmdValid && !colCmdWrite) |-> sinceWr >= BURST + WR_GAP); // R10
  AST_ACT_AFTER_PRE: assert property (@(posedge clk) disable iff (rst)
    (rowCmdValid && rowCmdAct) |-> sincePre >= T_RP); // R4

endmodule

bind splitCmdSched splitCmdSchedChecker #(
  .BURST(BURST), .WR_GAP(WR_GAP), .T_RP(T_RP)
) i_chk (
  .clk(clk), .rst(rst), .rowCmdValid(rowCmdValid), .rowCmdAct(rowCmdAct),
  .colCmdValid(colCmdValid), .colCmdWrite(colCmdWrite), .dataBusy(dataBusy)
);

// File: tb/test_splitCmdSched.sv
`timescale 1ns/1ps
module test_splitCmdSched;

  localparam int BURST  = 8;
  localparam int WR_GAP = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [4:0] reqDev = '0;
  logic [3:0] reqBank = '0;
  logic [7:0] reqRow = '0;
  logic [5:0] reqCol = '0;
  logic reqReady, rowCmdValid, rowCmdAct, colCmdValid, colCmdWrite;
  logic dataBusy, dataWrite;
  logic [4:0] rowCmdDev, colCmdDev, dataDev;
  logic [3:0] rowCmdBank, colCmdBank;
  logic [7:0] rowCmdRow;
  logic [5:0] colCmdCol;

  always #2.5 clk = ~clk;

  splitCmdSched i_splitCmdSched (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqDev(reqDev), .reqBank(reqBank), .reqRow(reqRow),
    .reqCol(reqCol), .rowCmdValid(rowCmdValid), .rowCmdAct(rowCmdAct),
    .rowCmdDev(rowCmdDev), .rowCmdBank(rowCmdBank), .rowCmdRow(rowCmdRow),
    .colCmdValid(colCmdValid), .colCmdWrite(colCmdWrite), .colCmdDev(colCmdDev),
    .colCmdBank(colCmdBank), .colCmdCol(colCmdCol), .dataBusy(dataBusy),
    .dataWrite(dataWrite), .dataDev(dataDev)
  );

  int compared = 0, mismatched = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // event log, sampled on the falling edge
  int preCnt, actCnt, firstPreCyc, firstPreBank, colN, busyCnt, dataDevSeen, dataWrSeen;
  int colCyc[4], colDevL[4], colBankL[4], colWrL[4];
  bit overlap;

  always @(negedge clk) begin
    if (!rst) begin
      if (rowCmdValid) begin
        if (rowCmdAct) actCnt++;
        else begin
          if (preCnt == 0) begin firstPreCyc = cyc; firstPreBank = int'(rowCmdBank); end
          preCnt++;
        end
      end
      if (colCmdValid && colN < 4) begin
        colCyc[colN] = cyc; colDevL[colN] = int'(colCmdDev);
        colBankL[colN] = int'(colCmdBank); colWrL[colN] = int'(colCmdWrite);
        colN++;
      end
      if (rowCmdValid && colCmdValid) overlap = 1'b1;
      if (dataBusy) begin
        if (busyCnt == 0) begin dataDevSeen = int'(dataDev); dataWrSeen = int'(dataWrite); end
        busyCnt++;
      end
    end
  end

  task automatic clearLog();
    preCnt = 0; actCnt = 0; firstPreCyc = -1; firstPreBank = -1; colN = 0;
    busyCnt = 0; dataDevSeen = -1; dataWrSeen = -1; overlap = 1'b0;
    for (int i = 0; i < 4; i++) begin
      colCyc[i] = -1; colDevL[i] = -1; colBankL[i] = -1; colWrL[i] = -1;
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic sendReq(input int wr, input int dev, input int bank, input int row, output int acc);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr[0]; reqDev = 5'(dev);
    reqBank = 4'(bank); reqRow = 8'(row); reqCol = 6'(dev + bank);
    while (!reqReady) @(negedge clk);
    acc = cyc;
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string tagName(input int t);
    case (t)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R6";
    endcase
  endfunction

  typedef struct packed {
    int wr; int dev; int bank; int row; int pres; int preBank; int lat; int tag;
  } vecT;

  // isolated requests run in this order; bank state carries over
  localparam vecT VECS [10] = '{
    '{0,  3,  5,  10, 0, 0,  4, 2},   // closed bank
    '{0,  3,  5,  10, 0, 0,  2, 3},   // same row open
    '{1,  3,  5,  11, 1, 5,  7, 4},   // other row in target
    '{0,  3,  7,   1, 0, 0,  4, 5},   // two away: unaffected
    '{0,  3,  6,   2, 2, 5,  8, 5},   // both neighbours open
    '{0,  4,  6,   2, 0, 0,  4, 6},   // other device
    '{1, 31, 15, 255, 0, 0,  4, 2},   // top edge bank
    '{0, 31, 14,   0, 1, 15, 7, 5},   // single neighbour at edge
    '{0,  0,  0,   0, 0, 0,  4, 2},   // bottom edge bank
    '{0,  0,  1,   0, 1, 0,  7, 5}    // neighbour bank 0 open
  };

  initial begin
    repeat (2000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int accA, accB;
    clearLog();
    repeat (3) @(negedge clk);
    // R1 reset state while reset is held and after release
    chk("R1 ready in reset", int'(reqReady), 1);
    chk("R1 row cmd in reset", int'(rowCmdValid), 0);
    chk("R1 col cmd in reset", int'(colCmdValid), 0);
    chk("R1 busy in reset", int'(dataBusy), 0);
    @(posedge clk); #1 rst = 1'b0;
    idle(3);
    chk("R1 no commands after reset", actCnt + preCnt + colN + busyCnt, 0);

    for (int i = 0; i < 10; i++) begin
      clearLog();
      sendReq(VECS[i].wr, VECS[i].dev, VECS[i].bank, VECS[i].row, accA);
      idle(24);
      chk({tagName(VECS[i].tag), " precharges"}, preCnt, VECS[i].pres);
      chk({tagName(VECS[i].tag), " activates"}, actCnt, (VECS[i].lat == 2) ? 0 : 1);
      if (VECS[i].pres > 0)
        chk({tagName(VECS[i].tag), " first precharge bank"}, firstPreBank, VECS[i].preBank);
      chk({tagName(VECS[i].tag), " column latency"}, colCyc[0] - accA, VECS[i].lat);
      chk("R8 column device", colDevL[0], VECS[i].dev);
      chk("R8 column bank", colBankL[0], VECS[i].bank);
      chk("R8 column direction", colWrL[0], VECS[i].wr);
      chk("R8 data slot length", busyCnt, BURST);
      chk("R8 data slot device", dataDevSeen, VECS[i].dev);
      chk("R8 data slot direction", dataWrSeen, VECS[i].wr);
    end

    // R7 and R9: activate of B coincides with column of A; reads to two devices back to back
    clearLog();
    sendReq(0, 1, 2, 0, accA);
    sendReq(0, 2, 3, 0, accB);
    idle(30);
    chk("R7 row and column in one cycle", int'(overlap), 1);
    chk("R9 read-read other device spacing", colCyc[1] - colCyc[0], BURST);
    chk("R9 contiguous data cycles", busyCnt, 2 * BURST);

    // R10 read after write
    clearLog();
    sendReq(1, 5, 0, 0, accA);
    sendReq(0, 6, 0, 0, accB);
    idle(30);
    chk("R10 write-read spacing", colCyc[1] - colCyc[0], BURST + WR_GAP);
    chk("R10 read direction", colWrL[1], 0);

    // R9 write after read
    clearLog();
    sendReq(0, 8, 0, 0, accA);
    sendReq(1, 9, 0, 0, accB);
    idle(30);
    chk("R9 read-write spacing", colCyc[1] - colCyc[0], BURST);

    // R11 precharge held until the column stage leaves the bank
    clearLog();
    sendReq(0, 7, 4, 0, accA);
    sendReq(0, 7, 4, 1, accB);
    idle(30);
    chk("R11 precharge after column", firstPreCyc - colCyc[0], 1);
    chk("R11 precharge bank", firstPreBank, 4);
    chk("R11 second column spacing", colCyc[1] - colCyc[0], BURST);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule